// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous host to an external asynchronous static RAM of 128K words by 8 bits. The host presents one read or write at a time on a valid/ready port. The controller turns each request into a registered address, a pair of chip selects, an active-low write strobe, an active-low output enable and an 8-bit data bus. The chip selects have opposite polarity: one is active low and one is active high. The data bus comes out as separate output data, output enable and input data signals, so the pad ring can build the tri-state buffer.

All memory timing is met by counting system clock cycles. The clock period and the speed grade (70 ns or 100 ns) are parameters. Each timing figure in nanoseconds is rounded up to whole cycles. A read or write acknowledge pulses on the response port when the chip is deselected.

A power-down input keeps both chip selects inactive for as long as it is held. After it is released, the controller waits a recovery time (5 ms by default) with the chip still deselected before it accepts the next request.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset, both chip selects are inactive (`mem_cs1_n`=1, `mem_cs2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0. `req_ready`=1 while `pd_req` is low.
- R2: The chip is selected (`mem_cs1_n`=0 and `mem_cs2`=1) only during an access. A write keeps it selected for WR_CYC = max(ceil(tCYC/T), WE_CYC+1) cycles and a read for RD_CYC cycles. `mem_addr` holds the accepted address and does not change while the chip is selected.
- R3: A write drives `mem_we_n` low on the same edge that selects the chip. It holds the strobe low for WE_CYC = max(ceil(tWP/T), ceil(tDS/T)) cycles, where tWP is 55/75 ns and tDS is 30/40 ns. So the strobe is low for at least tWP and the data is stable for at least tDS before the strobe rises.
- R4: During a write, `mem_dq_oe` is 1 and `mem_dq_o` equals the accepted write data from the select edge until the chip is deselected, which includes the cycle after `mem_we_n` rises. `mem_oe_n` stays 1 throughout the write.
- R5: A read holds `mem_oe_n` low for RD_CYC = max(ceil(tCYC/T), ceil(tOE/T)) cycles, where tOE is 35/50 ns. On the edge that ends the access, the controller captures `mem_dq_i` into `rsp_rdata`. That value equals the byte last written to the same address.
- R6: `rsp_valid` is a one-cycle pulse, raised on the edge that deselects the chip at the end of every read and every write.
- R7: `req_ready` is 1 only when no access or power-down is in progress and `pd_req` is low. A request is taken on a cycle where `req_valid` and `req_ready` are both 1. A request presented while `req_ready` is 0 causes no pin activity and does not change memory.
- R8: While `pd_req` is 1 and no access is running, the chip stays deselected and `req_ready` stays 0. If `pd_req` rises during an access, that access completes at full length first.
- R9: After `pd_req` falls, `req_ready` stays 0 for PD_CYC = ceil(tPDR/T) cycles with the chip deselected. If `pd_req` rises again during that wait, the wait restarts from the beginning once `pd_req` is released.
- R10: `mem_dq_oe` and a low `mem_oe_n` are never active together. When a read follows a write, at least one cycle with `mem_dq_oe`=0 comes before `mem_oe_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access finished (one-cycle pulse) |
| rsp_rdata | output | 8 | Data captured by the last read |
| pd_req | input | 1 | Hold the memory deselected for power-down |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
A wrong sequencer state or a miscounted cycle counter shows at the pins within one access. The length of the select, strobe or output-enable window changes, and the pin-level checks measure that length when the chip is deselected. If the read capture is mistimed, `rsp_rdata` takes the garbage value the memory model returns before its access time has elapsed. The mismatch is visible in the same cycle as `rsp_valid`. An error in the power-down wait moves the cycle in which `req_ready` returns, and the bench counts that directly.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and timing helpers for the SRAM controller.
// Assumes all timing figures are whole nanoseconds.
package sram_ctrl_pkg;

    // Sequencer states; every pin pattern is decoded from one of these.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_LO,
        ST_WR_HI,
        ST_PD,
        ST_PD_REC
    } st_e;

    // Round a duration in ns up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cnt.sv
`timescale 1ns/1ps
// Loadable down counter used to time one sequencer phase.
// Assumes load has priority; the counter parks at zero.
module sram_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
// Access sequencer: picks the phase, times it with counters, and
// produces accept/done strobes. Assumes phase lengths of at least 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 7,
    parameter int WE_CYC = 6,
    parameter int WT_CYC = 1,
    parameter int PD_CYC = 500000,
    parameter int ACC_W  = 3,
    parameter int PD_W   = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic pd_req,
    output st_e  st_q,
    output st_e  st_nxt,
    output logic accept,
    output logic done,
    output logic ready
);
    localparam logic [ACC_W-1:0] RD_LD = ACC_W'(RD_CYC - 1);
    localparam logic [ACC_W-1:0] WE_LD = ACC_W'(WE_CYC - 1);
    localparam logic [ACC_W-1:0] WT_LD = ACC_W'(WT_CYC - 1);
    localparam logic [PD_W-1:0]  PD_LD = PD_W'(PD_CYC - 1);

    logic             acc_zero, pd_zero, acc_load, pd_load;
    logic [ACC_W-1:0] acc_val;

    assign ready  = (st_q == ST_IDLE) && !pd_req;
    assign accept = ready && req_valid;
    assign done   = ((st_q == ST_RD) || (st_q == ST_WR_HI)) && acc_zero;

    // Next phase from the current phase, counters and host inputs.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   if (pd_req) st_nxt = ST_PD;
                       else if (req_valid) st_nxt = req_write ? ST_WR_LO : ST_RD;
            ST_RD:     if (acc_zero) st_nxt = ST_IDLE;
            ST_WR_LO:  if (acc_zero) st_nxt = ST_WR_HI;
            ST_WR_HI:  if (acc_zero) st_nxt = ST_IDLE;
            ST_PD:     if (!pd_req) st_nxt = ST_PD_REC;
            ST_PD_REC: if (pd_req) st_nxt = ST_PD;
                       else if (pd_zero) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // Phase length loaded on entry to each timed phase.
    always_comb begin
        unique case (st_nxt)
            ST_RD:    acc_val = RD_LD;
            ST_WR_LO: acc_val = WE_LD;
            ST_WR_HI: acc_val = WT_LD;
            default:  acc_val = '0;
        endcase
    end

    assign acc_load = (st_nxt != st_q);
    assign pd_load  = (st_nxt == ST_PD_REC) && (st_q != ST_PD_REC);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    sram_cnt #(.W(ACC_W)) u_acc_cnt (
        .clk(clk), .rst_n(rst_n), .load(acc_load), .load_val(acc_val), .zero(acc_zero)
    );

    sram_cnt #(.W(PD_W)) u_pd_cnt (
        .clk(clk), .rst_n(rst_n), .load(pd_load), .load_val(PD_LD), .zero(pd_zero)
    );
endmodule

// File: rtl/sram_pins.sv
`timescale 1ns/1ps
// Pin stage: registers every memory pin from the next phase so the
// strobes are glitch free, holds address and write data, captures reads.
module sram_pins
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               st_q,
    input  st_e               st_nxt,
    input  logic              accept,
    input  logic              done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic sel_nxt, wr_nxt;

    assign wr_nxt  = (st_nxt == ST_WR_LO) || (st_nxt == ST_WR_HI);
    assign sel_nxt = wr_nxt || (st_nxt == ST_RD);

    // Strobes and bus drive decoded from the coming phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs1_n <= !sel_nxt;
            mem_cs2   <= sel_nxt;
            mem_we_n  <= (st_nxt != ST_WR_LO);
            mem_oe_n  <= (st_nxt != ST_RD);
            mem_dq_oe <= wr_nxt;
        end
    end

    // Address and write data latched on acceptance, held to the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Read capture at the edge closing the access, plus the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (done && (st_q == ST_RD)) rsp_rdata <= mem_dq_i;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
// Asynchronous SRAM controller top. Converts single host requests into
// cycle-counted read/write accesses and a held power-down deselect.
// Assumes CLK_NS is the system clock period in whole ns and that the
// memory timing follows the selected GRADE_NS (70 or 100).
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int GRADE_NS  = 70,
    parameter int PD_REC_NS = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              pd_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam bit SLOW     = (GRADE_NS >= 100);
    localparam int T_WP_NS  = SLOW ? 75 : 55;
    localparam int T_DS_NS  = SLOW ? 40 : 30;
    localparam int T_OE_NS  = SLOW ? 50 : 35;
    localparam int RD_CYC   = max2(ns2cyc(GRADE_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
    localparam int WE_CYC   = max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
    localparam int WR_CYC   = max2(ns2cyc(GRADE_NS, CLK_NS), WE_CYC + 1);
    localparam int WT_CYC   = WR_CYC - WE_CYC;
    localparam int PD_CYC   = max2(ns2cyc(PD_REC_NS, CLK_NS), 1);
    localparam int ACC_W    = $clog2(max2(RD_CYC, max2(WE_CYC, WT_CYC)) + 1);
    localparam int PD_W     = $clog2(PD_CYC + 1);

    st_e  st_q, st_nxt;
    logic accept, done;

    sram_seq #(
        .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .WT_CYC(WT_CYC), .PD_CYC(PD_CYC),
        .ACC_W(ACC_W), .PD_W(PD_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .pd_req(pd_req), .st_q(st_q), .st_nxt(st_nxt), .accept(accept),
        .done(done), .ready(req_ready)
    );

    sram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .st_nxt(st_nxt), .accept(accept),
        .done(done), .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sram_ctrl pins, attached by bind below.
module sram_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_req,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic sel;
    assign sel = !mem_cs1_n && mem_cs2;

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_strobe_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> sel);

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

    assert_we_oe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    assert_hold_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && sel) |-> mem_dq_oe);

    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sel);

    assert_pd_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req && !sel) |=> !sel);

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_at_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!sel && $past(sel)));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
    .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
// Bench: a behavioural SRAM model with timing-rule checks, a pin monitor
// that measures every access window, and directed plus random traffic.
module tb_sram_ctrl;
    localparam int CLK_NS  = 10;
    localparam int HALF    = CLK_NS / 2;
    localparam int PDR_NS  = 1500;
    localparam int EXP_RD  = (70 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_WE  = (55 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_WR  = (EXP_RD > EXP_WE + 1) ? EXP_RD : EXP_WE + 1;
    localparam int EXP_PD  = (PDR_NS + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, pd_req = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i;
    logic [16:0] mem_addr;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0, mon_on = 1'b0;
    logic [7:0] exp_mem [int];
    logic [7:0] sram    [int];
    int  cur_addr = 0;
    logic [7:0] cur_wdata = '0;

    always #(HALF) clk = ~clk;

    sram_ctrl #(.CLK_NS(CLK_NS), .GRADE_NS(70), .PD_REC_NS(PDR_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pd_req(pd_req),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pin monitor and memory model, evaluated on every falling edge.
    bit sel_p = 0, wr_p = 0, oe_low_p = 0, dqoe_p = 0;
    int sel_len = 0, we_len = 0, oe_len = 0;
    int t_sel = 0, t_we = 0, t_d = 0, t_oe = 0;
    logic [16:0] addr_p = '0;
    logic [7:0]  dq_p = '0;
    initial mem_dq_i = 8'hEE;
    always @(negedge clk) begin
        bit sel, wr;
        int now_e;
        sel   = !mem_cs1_n && mem_cs2;
        wr    = sel && !mem_we_n;
        now_e = int'($time) - HALF;
        if (mon_on) begin
            chk(!(mem_dq_oe && !mem_oe_n), "R10 bus contention", 1, 0);
            if (sel && sel_p) chk(mem_addr == addr_p, "R2 addr stable", mem_addr, addr_p);
            if (sel && !sel_p) begin
                t_sel = now_e;
                chk(mem_addr == cur_addr[16:0], "R2 addr", mem_addr, cur_addr);
            end
            if (sel) chk(!req_ready, "R7 ready during access", req_ready, 0);
            if (wr && !wr_p) t_we = now_e;
            if (mem_dq_oe && (!dqoe_p || mem_dq_o != dq_p)) t_d = now_e;
            if (!mem_oe_n && !oe_low_p) begin
                t_oe = now_e;
                chk(!dqoe_p, "R10 release before OE", dqoe_p, 0);
            end
            if (wr_p && !wr) begin
                chk(now_e - t_we >= 55, "R3 strobe width ns", now_e - t_we, 55);
                chk(now_e - t_d >= 30, "R3 data setup ns", now_e - t_d, 30);
                chk(mem_dq_oe && mem_dq_o == dq_p, "R4 hold after strobe", mem_dq_oe, 1);
                chk(dq_p == cur_wdata, "R4 write data", dq_p, cur_wdata);
                sram[int'(addr_p)] = dq_p;
            end
            if (sel) begin
                sel_len++;
                if (!mem_we_n) we_len++;
                if (!mem_oe_n) oe_len++;
                if (mem_dq_oe) chk(mem_oe_n, "R4 OE high in write", mem_oe_n, 1);
            end
            if (sel_p && !sel) begin
                chk(rsp_valid, "R6 done pulse", rsp_valid, 1);
                if (we_len > 0) begin
                    chk(we_len == EXP_WE, "R3 strobe cycles", we_len, EXP_WE);
                    chk(sel_len == EXP_WR, "R2 write select cycles", sel_len, EXP_WR);
                    chk(oe_len == 0, "R4 no OE in write", oe_len, 0);
                end else begin
                    chk(oe_len == EXP_RD, "R5 OE cycles", oe_len, EXP_RD);
                    chk(sel_len == EXP_RD, "R2 read select cycles", sel_len, EXP_RD);
                    if (exp_mem.exists(cur_addr))
                        chk(rsp_rdata == exp_mem[cur_addr], "R5 read data", rsp_rdata, exp_mem[cur_addr]);
                end
                sel_len = 0; we_len = 0; oe_len = 0;
            end else if (rsp_valid) begin
                chk(1'b0, "R6 stray done", 1, 0);
            end
        end
        // Memory drives valid data only once access times elapse by the next edge.
        if (sel && !mem_oe_n && mem_we_n &&
            (int'($time) + HALF - t_oe >= 35) && (int'($time) + HALF - t_sel >= 70))
            mem_dq_i = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h5A;
        else
            mem_dq_i = 8'hEE;
        sel_p = sel; wr_p = wr; oe_low_p = !mem_oe_n; dqoe_p = mem_dq_oe;
        addr_p = mem_addr; dq_p = mem_dq_o;
    end

    task automatic host_req(input bit w, input int a, input logic [7:0] d);
        @(negedge clk);
        cur_addr = a; if (w) cur_wdata = d;
        req_valid = 1'b1; req_write = w; req_addr = a[16:0]; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (w) exp_mem[a] = d;
        while (!rsp_valid) @(negedge clk);
    endtask

    task automatic measure_recovery(input string tag);
        int n = 0;
        @(negedge clk); pd_req = 1'b0;
        forever begin
            @(negedge clk);
            if (req_ready || n > EXP_PD + 10) break;
            chk(mem_cs1_n && !mem_cs2, "R9 deselected in wait", mem_cs1_n, 1);
            n++;
        end
        chk(n == EXP_PD, tag, n, EXP_PD);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs1_n && !mem_cs2, "R1 selects idle", {mem_cs1_n, mem_cs2}, 2);
        chk(mem_we_n && mem_oe_n, "R1 strobes high", {mem_we_n, mem_oe_n}, 3);
        chk(!mem_dq_oe && !rsp_valid, "R1 bus off", {mem_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
        mon_on = 1'b1;

        // Boundary addresses, then read-after-write on the same word.
        host_req(1, 0, 8'hA5);
        host_req(1, 17'h1FFFF, 8'h3C);
        host_req(0, 0, 8'h00);
        host_req(0, 17'h1FFFF, 8'h00);
        host_req(1, 17'h00F0F, 8'h81);
        host_req(0, 17'h00F0F, 8'h00);

        // Random writes then read-back (R5).
        begin
            int addrs [20];
            for (int i = 0; i < 20; i++) begin
                addrs[i] = int'($urandom_range(17'h1FFFF, 1));
                host_req(1, addrs[i], 8'($urandom));
            end
            for (int i = 19; i >= 0; i--) host_req(0, addrs[i], 8'h00);
        end

        // Power-down with an ignored request, then recovery (R7, R8, R9).
        @(negedge clk); pd_req = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_wdata = 8'hFF;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!req_ready, "R8 ready low in power-down", req_ready, 0);
            chk(mem_cs1_n && !mem_cs2 && mem_we_n, "R7 ignored request", mem_we_n, 1);
        end
        req_valid = 1'b0;
        measure_recovery("R9 recovery cycles");
        host_req(0, 0, 8'h00);

        // Re-assert during the wait restarts it (R9).
        @(negedge clk); pd_req = 1'b1;
        repeat (5) @(negedge clk);
        pd_req = 1'b0;
        repeat (50) @(negedge clk);
        chk(!req_ready, "R9 still waiting", req_ready, 0);
        pd_req = 1'b1;
        repeat (3) @(negedge clk);
        measure_recovery("R9 restarted recovery");

        // Power-down raised mid-access lets it finish (R8).
        @(negedge clk);
        cur_addr = 17'h1FFFF;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        pd_req = 1'b1;
        while (!rsp_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!req_ready && mem_cs1_n && !mem_cs2, "R8 power-down after access", req_ready, 0);
        measure_recovery("R9 recovery after access");
        host_req(1, 5, 8'h77);
        host_req(0, 5, 8'h00);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule